// File: doc/BRIEF.md
# DDR Input 1:4 Gearbox

This block receives a double-data-rate serial input on one pin and turns it into parallel words in a system clock domain. The pin is sampled on both edges of a fast strobe clock. In normal mode each strobe period yields a two-bit word: the bit taken on the rising edge and the bit taken on the following falling edge. In gearbox mode two strobe periods are combined into one four-bit word. The system clock then runs at half the strobe rate. The design models the receive halves of two neighbouring I/O cells that are joined for this purpose.

Data moves through three register stages. Edge capture takes the rising and falling bits. A packer in the strobe domain pairs the two bits and, in gearbox mode, joins two pairs into one word. A transfer stage moves the word into the system clock domain. Its sampling edge is chosen by a polarity input, so the crossing can be moved half a system period to gain timing margin. The word that follows a polarity change is flagged invalid.

Top module: `ddr_gbx_rx`

## Requirements
- R1: While `rst_ni` is low, `vld_o` is 0 and `dout_o` is 0.
- R2: In gearbox mode (`gb_en_i`=1), each valid word holds four consecutive pin bits. The earliest bit is on `dout_o[0]`, then `dout_o[1]`, `dout_o[2]` and `dout_o[3]`. Bits 0 and 2 are taken on rising strobe edges and bits 1 and 3 on falling strobe edges.
- R3: After reset release in gearbox mode, the first valid word holds pin bits 0 to 3. Bit 0 is the bit sampled on the first rising strobe edge after release. `vld_o` rises within 6 system clock cycles of release.
- R4: Once `vld_o` is high, it stays high on every system cycle until reset or a polarity change. Each word is the group of bits that follows the previous word.
- R5: In normal mode (`gb_en_i`=0, system clock at the strobe rate), `dout_o[0]` carries the rising-edge bit and `dout_o[1]` the falling-edge bit that follows it. A new pair appears every system cycle, and the first valid pair is pin bits 0 and 1.
- R6: In normal mode, `dout_o[3:2]` is held at 0.
- R7: With `pol_i`=0 the transfer stage samples on the rising system clock edge, and with `pol_i`=1 on the falling edge. R2 to R4 hold under either setting.
- R8: The output registered on the first rising system clock edge after `pol_i` changes has `vld_o`=0. Valid words resume within 4 cycles and follow on consecutively.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk_i | input | 1 | Strobe clock; the pin is sampled on both edges |
| sys_clk_i | input | 1 | System clock (half the strobe rate in gearbox mode) |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 1 | Serial DDR data pin |
| pol_i | input | 1 | Transfer-stage sampling edge: 0 rising, 1 falling |
| gb_en_i | input | 1 | 1 selects the four-bit gearbox, 0 the two-bit capture |
| dout_o | output | 4 | Parallel word; bit 0 holds the earliest bit |
| vld_o | output | 1 | Word on `dout_o` is valid |

## Verification
A wrong packer phase shifts the group boundary. The first valid word after reset then differs from pin bits 0 to 3, so the fault shows within the start-up window. An edge-order or lane-order fault shows as swapped bits in the very first word. A transfer stage that drops or repeats words breaks the consecutive sequence, or drops `vld_o`, on the next system cycle. A missed polarity change leaves `vld_o` high on the cycle right after the change.

// File: rtl/ddr_gbx_pkg.sv
package ddr_gbx_pkg;
  localparam int unsigned LANES  = 2;          // bits per strobe period
  localparam int unsigned GROUPS = 2;          // strobe periods per gearbox word
  localparam int unsigned WORD_W = LANES * GROUPS;

  typedef logic [LANES-1:0]  pair_t;
  typedef logic [WORD_W-1:0] word_t;
endpackage

// File: rtl/ddr_gbx_capture.sv
module ddr_gbx_capture
  import ddr_gbx_pkg::*;
(
  input  logic  sclk_i,
  input  logic  rst_ni,
  input  logic  din_i,
  output pair_t pair_o,
  output logic  pair_vld_o
);
  logic rise_q, fall_q, live_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rise_q <= 1'b0;
      live_q <= 1'b0;
    end else begin
      rise_q <= din_i;
      live_q <= 1'b1;
    end
  end

  always_ff @(negedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) fall_q <= 1'b0;
    else         fall_q <= din_i;
  end

  // pair is complete at a rising edge once one rising sample exists
  assign pair_o     = {fall_q, rise_q};
  assign pair_vld_o = live_q;
endmodule

// File: rtl/ddr_gbx_pack.sv
module ddr_gbx_pack
  import ddr_gbx_pkg::*;
(
  input  logic  sclk_i,
  input  logic  rst_ni,
  input  logic  gb_en_i,
  input  pair_t pair_i,
  input  logic  pair_vld_i,
  output word_t word_o,
  output logic  word_vld_o
);
  logic  ph_q;
  pair_t low_q;
  word_t word_q;
  logic  wvld_q;

  always_ff @(posedge sclk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ph_q   <= 1'b0;
      low_q  <= '0;
      word_q <= '0;
      wvld_q <= 1'b0;
    end else if (pair_vld_i) begin
      if (gb_en_i) begin
        ph_q <= ~ph_q;
        if (!ph_q) begin
          low_q <= pair_i;
        end else begin
          word_q <= {pair_i, low_q};
          wvld_q <= 1'b1;
        end
      end else begin
        word_q <= {{(WORD_W-LANES){1'b0}}, pair_i};
        wvld_q <= 1'b1;
      end
    end
  end

  assign word_o     = word_q;
  assign word_vld_o = wvld_q;
endmodule

// File: rtl/ddr_gbx_xfer.sv
module ddr_gbx_xfer
  import ddr_gbx_pkg::*;
(
  input  logic  sys_clk_i,
  input  logic  rst_ni,
  input  logic  pol_i,
  input  logic  gb_en_i,
  input  word_t word_i,
  input  logic  word_vld_i,
  output word_t dout_o,
  output logic  vld_o
);
  logic  sync_clk;
  word_t sync_q;
  logic  sync_vld_q;
  logic  pol_q;
  word_t dout_q;
  logic  vld_q;

  assign sync_clk = sys_clk_i ^ pol_i;

  always_ff @(posedge sync_clk or negedge rst_ni) begin
    if (!rst_ni) begin
      sync_q     <= '0;
      sync_vld_q <= 1'b0;
    end else begin
      sync_q     <= word_i;
      sync_vld_q <= word_vld_i;
    end
  end

  always_ff @(posedge sys_clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pol_q  <= 1'b0;
      dout_q <= '0;
      vld_q  <= 1'b0;
    end else begin
      pol_q  <= pol_i;
      dout_q <= gb_en_i ? sync_q : {{(WORD_W-LANES){1'b0}}, sync_q[LANES-1:0]};
      // sync sample may be torn across a polarity switch
      vld_q  <= sync_vld_q && (pol_q == pol_i);
    end
  end

  assign dout_o = dout_q;
  assign vld_o  = vld_q;
endmodule

// File: rtl/ddr_gbx_rx.sv
module ddr_gbx_rx
  import ddr_gbx_pkg::*;
(
  input  logic              sclk_i,
  input  logic              sys_clk_i,
  input  logic              rst_ni,
  input  logic              din_i,
  input  logic              pol_i,
  input  logic              gb_en_i,
  output logic [WORD_W-1:0] dout_o,
  output logic              vld_o
);
  pair_t pair;
  logic  pair_vld;
  word_t word;
  logic  word_vld;

  ddr_gbx_capture u_cap (
    .sclk_i     (sclk_i),
    .rst_ni     (rst_ni),
    .din_i      (din_i),
    .pair_o     (pair),
    .pair_vld_o (pair_vld)
  );

  ddr_gbx_pack u_pack (
    .sclk_i     (sclk_i),
    .rst_ni     (rst_ni),
    .gb_en_i    (gb_en_i),
    .pair_i     (pair),
    .pair_vld_i (pair_vld),
    .word_o     (word),
    .word_vld_o (word_vld)
  );

  ddr_gbx_xfer u_xfer (
    .sys_clk_i  (sys_clk_i),
    .rst_ni     (rst_ni),
    .pol_i      (pol_i),
    .gb_en_i    (gb_en_i),
    .word_i     (word),
    .word_vld_i (word_vld),
    .dout_o     (dout_o),
    .vld_o      (vld_o)
  );
endmodule

// File: rtl/ddr_gbx_rx_chk.sv
module ddr_gbx_rx_chk
  import ddr_gbx_pkg::*;
(
  input logic              sys_clk_i,
  input logic              rst_ni,
  input logic              pol_i,
  input logic              gb_en_i,
  input logic [WORD_W-1:0] dout_o,
  input logic              vld_o,
  input logic              word_vld_i
);
  // R4
  vld_sticky_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    vld_o |=> (vld_o || ($past(pol_i) != $past(pol_i, 2))));

  // R6
  b_zero_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    !$past(gb_en_i) |-> (dout_o[WORD_W-1:LANES] == '0));

  // R8
  pol_drop_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    (pol_i != $past(pol_i)) |=> !vld_o);

  // R3
  vld_after_fill_chk: assert property (@(posedge sys_clk_i) disable iff (!rst_ni)
    vld_o |-> word_vld_i);
endmodule

bind ddr_gbx_rx ddr_gbx_rx_chk u_chk (
  .sys_clk_i  (sys_clk_i),
  .rst_ni     (rst_ni),
  .pol_i      (pol_i),
  .gb_en_i    (gb_en_i),
  .dout_o     (dout_o),
  .vld_o      (vld_o),
  .word_vld_i (word_vld)
);

// File: tb/ddr_gbx_rx_tb.sv
`timescale 1ns/100ps
module ddr_gbx_rx_tb;
  logic       sclk = 1'b0, sys_clk = 1'b0, rst_n = 1'b0;
  logic       din = 1'b0, pol = 1'b0, gb_en = 1'b1;
  logic [3:0] dout;
  logic       vld;
  realtime    sys_half = 10.0;
  int         n_chk = 0, n_err = 0, idx = 0;
  logic       drv_on = 1'b0;

  always #5 sclk = ~sclk;                      // 100 MHz strobe
  initial begin
    #2.5;
    forever begin sys_clk = ~sys_clk; #(sys_half); end
  end

  ddr_gbx_rx u_dut (
    .sclk_i(sclk), .sys_clk_i(sys_clk), .rst_ni(rst_n), .din_i(din),
    .pol_i(pol), .gb_en_i(gb_en), .dout_o(dout), .vld_o(vld)
  );

  function automatic logic [3:0] nib(int k);
    return 4'((k * 7 + 3) & 15);
  endfunction
  function automatic logic bit_at(int i);
    logic [3:0] n;
    n = nib(i / 4);
    return n[i % 4];
  endfunction
  function automatic logic [1:0] pair_at(int k);
    return {bit_at(2*k + 1), bit_at(2*k)};
  endfunction

  always @(sclk) if (drv_on) begin #1; din = bit_at(idx); idx++; end

  task automatic chk(bit ok, string req, string what, int act, int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic do_reset(bit gb, logic p, realtime half);
    drv_on = 1'b0; rst_n = 1'b0; gb_en = gb; pol = p; sys_half = half;
    repeat (3) @(posedge sys_clk);
    #1;
    chk(vld == 1'b0, "R1", "vld in reset", int'(vld), 0);
    chk(dout == 4'h0, "R1", "dout in reset", int'(dout), 0);
    @(negedge sclk); #1;
    rst_n = 1'b1; din = bit_at(0); idx = 1; drv_on = 1'b1;
  endtask

  task automatic wait_first(output int lat);
    lat = 0;
    do begin @(posedge sys_clk); #1; lat++; end while (!vld && lat < 20);
  endtask

  task automatic t_gear(logic p);
    int lat;
    do_reset(1'b1, p, 10.0);
    wait_first(lat);
    chk(lat <= 6, "R3", "cycles to first valid", lat, 6);
    chk(dout == nib(0), p ? "R7" : "R3", "first gearbox word", int'(dout), int'(nib(0)));
    for (int k = 1; k < 12; k++) begin
      @(posedge sys_clk); #1;
      chk(vld == 1'b1, "R4", "valid held", int'(vld), 1);
      chk(dout == nib(k), p ? "R7" : "R2", "gearbox word", int'(dout), int'(nib(k)));
    end
  endtask

  task automatic t_normal();
    int lat;
    do_reset(1'b0, 1'b0, 5.0);
    wait_first(lat);
    chk(lat <= 6, "R5", "cycles to first valid", lat, 6);
    chk(dout[1:0] == pair_at(0), "R5", "first pair", int'(dout[1:0]), int'(pair_at(0)));
    chk(dout[3:2] == 2'b00, "R6", "upper lanes", int'(dout[3:2]), 0);
    for (int k = 1; k < 12; k++) begin
      @(posedge sys_clk); #1;
      chk(vld == 1'b1, "R5", "valid held", int'(vld), 1);
      chk(dout[1:0] == pair_at(k), "R5", "pair", int'(dout[1:0]), int'(pair_at(k)));
      chk(dout[3:2] == 2'b00, "R6", "upper lanes", int'(dout[3:2]), 0);
    end
  endtask

  task automatic t_polchg();
    int lat, kk, found, waitc;
    do_reset(1'b1, 1'b0, 10.0);
    wait_first(lat);
    kk = 0;
    for (int r = 0; r < 2; r++) begin
      for (int k = 0; k < 3; k++) begin
        @(posedge sys_clk); #1; kk++;
        chk(vld && dout == nib(kk), "R8", "word before switch", int'(dout), int'(nib(kk)));
      end
      pol = ~pol;
      @(posedge sys_clk); #1; kk++;
      chk(vld == 1'b0, "R8", "valid after switch", int'(vld), 0);
      waitc = 0;
      while (!vld && waitc < 4) begin @(posedge sys_clk); #1; kk++; waitc++; end
      chk(vld == 1'b1, "R8", "valid resumes", int'(vld), 1);
      found = -1;
      for (int j = kk - 2; j <= kk + 2; j++) if (dout == nib(j)) found = j;
      chk(found >= 0, "R8", "resumed word in sequence", int'(dout), int'(nib(kk)));
      if (found >= 0) kk = found;
      for (int k = 0; k < 4; k++) begin
        @(posedge sys_clk); #1; kk++;
        chk(vld && dout == nib(kk), "R8", "word after switch", int'(dout), int'(nib(kk)));
      end
    end
  endtask

  initial begin
    #500000;
    n_chk++; n_err++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    t_gear(1'b0);
    t_gear(1'b1);
    t_normal();
    t_polchg();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule